// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one logic cell of a programmable sum-of-products fabric. It receives a handful of product terms from the array and a cascade sum from a neighbouring cell. A per-term role field sends each product term into the OR sum or into a control job: cell clock, set, reset or output enable. The OR sum passes through an optional inverter. It then either drives the output directly or feeds a storage bit that behaves as a D or a T flip-flop.

The block runs on one system clock. The cell clock is one of several global clock lines, with an optional inversion, or a product term. The storage bit captures on a rising edge of that source, found by comparing it with its value at the previous system clock edge. Set and reset act at the next system clock edge whether or not the cell clock moves. A gated global set/reset line drives the bit to its configured power-up value. The output enable comes from a product term, a chosen global enable line, or a constant.

Top module: `sop_cell`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, the storage bit holds `cfg_preload_i`. The bench holds that input at 0 unless a test needs 1. In registered modes `out_o` shows the storage bit.
- R2: Each product term has a 3-bit role in `cfg_role_i[3*i+2:3*i]`. The codes are 0 data, 1 clock, 2 set, 3 reset, 4 output enable, and 5 to 7 unused. The sum is the OR of `casc_i` and every term with role 0. Terms with any other role do not reach the sum.
- R3: With `cfg_inv_i` high, the sum is inverted before it reaches the output or the storage bit.
- R4: `cfg_mode_i` 0 is D and 1 is T. Values 2 and 3 are bypass: `out_o` equals the sum combinationally, and the storage bit ignores cell clock edges.
- R5: In D mode, at a system clock edge where the selected cell clock source is high and was low at the previous edge, the storage bit takes the sum.
- R6: In T mode, such an edge inverts the storage bit when the sum is 1 and leaves it unchanged when the sum is 0.
- R7: `cfg_clk_sel_i` values 0 to 2 pick global clock 0 to 2, XORed with `cfg_clk_inv_i`. Value 3 picks the OR of the terms with role 1. Edges on sources that are not selected have no effect. The previous-source register resets to 1, so a source that is already high at reset does not count as an edge.
- R8: A product term with role 3 clears the storage bit at the next edge, and one with role 2 sets it. Neither depends on the cell clock. Clear beats set.
- R9: With `cfg_gsr_en_i` high, `gsr_i` drives the bit to `cfg_preload_i` at the next edge. This goes through the same clear-beats-set rule. With `cfg_gsr_en_i` low, `gsr_i` is ignored.
- R10: `cfg_oe_sel_i` sets `oe_o`. The codes are 0 for the OR of role-4 terms, 1 for `goe_i[cfg_goe_idx_i]`, 2 for constant 1 and 3 for constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| pt_i | input | 5 | Product terms from the array |
| casc_i | input | 1 | Cascade sum from a neighbouring cell |
| gclk_i | input | 3 | Global clock lines |
| gsr_i | input | 1 | Global set/reset line |
| goe_i | input | 4 | Global output-enable lines |
| cfg_role_i | input | 15 | Role code per product term, 3 bits each |
| cfg_inv_i | input | 1 | Invert the sum |
| cfg_mode_i | input | 2 | 0 D, 1 T, 2 or 3 bypass |
| cfg_clk_sel_i | input | 2 | Cell clock source select |
| cfg_clk_inv_i | input | 1 | Invert the selected global clock |
| cfg_gsr_en_i | input | 1 | Allow the global set/reset line to act |
| cfg_preload_i | input | 1 | Power-up and global set/reset value |
| cfg_oe_sel_i | input | 2 | Output-enable source select |
| cfg_goe_idx_i | input | 2 | Which global enable line to use |
| out_o | output | 1 | Cell output |
| oe_o | output | 1 | Cell output enable |

## Verification
The bench first runs directed sequences, then a long run in which every input changes at random each cycle. In bypass mode, single terms with different roles separate the data path from the control roles, and toggling the inversion bit separates R3 from R2. Clock tests move an unselected global clock, then flip the polarity while a line is high, then use a product-term clock. This distinguishes a real edge from a level and from a glitch caused by reselection. In the set/reset tests, clear and set are raised together, and `gsr_i` is raised with preload 0 and 1 and with its enable off. This exposes wrong priority or wrong gating.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

    localparam int ROLE_W = 3;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_DATA  = 3'd0,
        ROLE_CLK   = 3'd1,
        ROLE_SET   = 3'd2,
        ROLE_RST   = 3'd3,
        ROLE_OE    = 3'd4,
        ROLE_OFF   = 3'd5
    } pt_role_e;

    typedef enum logic [1:0] {
        MODE_D    = 2'd0,
        MODE_T    = 2'd1,
        MODE_BYP  = 2'd2,
        MODE_BYP2 = 2'd3
    } cell_mode_e;

    typedef enum logic [1:0] {
        OE_TERM  = 2'd0,
        OE_GLOB  = 2'd1,
        OE_ONE   = 2'd2,
        OE_ZERO  = 2'd3
    } oe_src_e;

    typedef struct packed {
        logic bit_v;
        logic src_prev;
    } store_state_t;

endpackage

// File: rtl/sop_term_steer.sv
module sop_term_steer
    import sop_cell_pkg::*;
#(
    parameter int NUM_PT = 5
) (
    input  logic [NUM_PT-1:0]        pt_i,
    input  logic                     casc_i,
    input  logic [NUM_PT*ROLE_W-1:0] role_i,
    input  logic                     inv_i,
    output logic                     sum_o,
    output logic                     clk_term_o,
    output logic                     set_term_o,
    output logic                     rst_term_o,
    output logic                     oe_term_o
);

    logic [NUM_PT-1:0] is_data, is_clk, is_set, is_rst, is_oe;

    for (genvar g = 0; g < NUM_PT; g++) begin : g_role
        logic [ROLE_W-1:0] code;
        assign code       = role_i[g*ROLE_W +: ROLE_W];
        assign is_data[g] = (code == ROLE_DATA);
        assign is_clk[g]  = (code == ROLE_CLK);
        assign is_set[g]  = (code == ROLE_SET);
        assign is_rst[g]  = (code == ROLE_RST);
        assign is_oe[g]   = (code == ROLE_OE);
    end

    logic raw_sum;
    always_comb begin
        raw_sum    = casc_i | (|(pt_i & is_data));
        sum_o      = raw_sum ^ inv_i;
        clk_term_o = |(pt_i & is_clk);
        set_term_o = |(pt_i & is_set);
        rst_term_o = |(pt_i & is_rst);
        oe_term_o  = |(pt_i & is_oe);
    end

endmodule

// File: rtl/sop_store_bit.sv
module sop_store_bit
    import sop_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       preload_i,
    input  logic       src_i,
    input  logic [1:0] mode_i,
    input  logic       d_i,
    input  logic       clr_i,
    input  logic       set_i,
    output logic       q_o
);

    store_state_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d          = st_q;
        rise          = src_i & ~st_q.src_prev;
        st_d.src_prev = src_i;
        if (clr_i) begin
            st_d.bit_v = 1'b0;
        end else if (set_i) begin
            st_d.bit_v = 1'b1;
        end else if (rise) begin
            case (mode_i)
                MODE_D:  st_d.bit_v = d_i;
                MODE_T:  st_d.bit_v = st_q.bit_v ^ d_i;
                default: st_d.bit_v = st_q.bit_v;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bit_v    <= preload_i;
            st_q.src_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bit_v;

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == 1'b0));

    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (q_o == 1'b1));

    assert_hold_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && !rise) |=> $stable(q_o));

    assert_d_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && mode_i == MODE_D && !clr_i && !set_i) |=> (q_o == $past(d_i)));

    assert_t_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && mode_i == MODE_T && d_i && !clr_i && !set_i) |=> (q_o != $past(q_o)));

endmodule

// File: rtl/sop_cell.sv
module sop_cell
    import sop_cell_pkg::*;
#(
    parameter int NUM_PT    = 5,
    parameter int NUM_GCLK  = 3,
    parameter int NUM_GOE   = 4,
    localparam int CSEL_W   = $clog2(NUM_GCLK + 1),
    localparam int GOE_W    = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1,
    localparam int ROLES_W  = NUM_PT * ROLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PT-1:0]   pt_i,
    input  logic                casc_i,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                gsr_i,
    input  logic [NUM_GOE-1:0]  goe_i,
    input  logic [ROLES_W-1:0]  cfg_role_i,
    input  logic                cfg_inv_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic [CSEL_W-1:0]   cfg_clk_sel_i,
    input  logic                cfg_clk_inv_i,
    input  logic                cfg_gsr_en_i,
    input  logic                cfg_preload_i,
    input  logic [1:0]          cfg_oe_sel_i,
    input  logic [GOE_W-1:0]    cfg_goe_idx_i,
    output logic                out_o,
    output logic                oe_o
);

    logic sum, clk_term, set_term, rst_term, oe_term;
    logic src, clr, set, q;

    sop_term_steer #(.NUM_PT(NUM_PT)) steer_i (
        .pt_i       (pt_i),
        .casc_i     (casc_i),
        .role_i     (cfg_role_i),
        .inv_i      (cfg_inv_i),
        .sum_o      (sum),
        .clk_term_o (clk_term),
        .set_term_o (set_term),
        .rst_term_o (rst_term),
        .oe_term_o  (oe_term)
    );

    always_comb begin
        if (int'(cfg_clk_sel_i) < NUM_GCLK) begin
            src = gclk_i[cfg_clk_sel_i] ^ cfg_clk_inv_i;
        end else begin
            src = clk_term;
        end
        clr = rst_term | (cfg_gsr_en_i & gsr_i & ~cfg_preload_i);
        set = set_term | (cfg_gsr_en_i & gsr_i &  cfg_preload_i);
    end

    sop_store_bit store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .preload_i (cfg_preload_i),
        .src_i     (src),
        .mode_i    (cfg_mode_i),
        .d_i       (sum),
        .clr_i     (clr),
        .set_i     (set),
        .q_o       (q)
    );

    always_comb begin
        out_o = cfg_mode_i[1] ? sum : q;
        case (cfg_oe_sel_i)
            OE_TERM: oe_o = oe_term;
            OE_GLOB: oe_o = (int'(cfg_goe_idx_i) < NUM_GOE) ? goe_i[cfg_goe_idx_i] : 1'b0;
            OE_ONE:  oe_o = 1'b1;
            default: oe_o = 1'b0;
        endcase
    end

endmodule

// File: tb/sop_cell_tb_top.sv
module sop_cell_tb_top;

    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  pt;
    logic        casc;
    logic [2:0]  gclk;
    logic        gsr;
    logic [3:0]  goe;
    logic [14:0] role;
    logic        inv;
    logic [1:0]  mode;
    logic [1:0]  csel;
    logic        cinv;
    logic        gsr_en;
    logic        pre;
    logic [1:0]  oesel;
    logic [1:0]  goeidx;
    logic        out_o, oe_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_req = "R1";

    logic mq;
    logic mprev;

    always #(TCK/2) clk = ~clk;

    sop_cell dut_i (
        .clk(clk), .rst_n(rst_n), .pt_i(pt), .casc_i(casc), .gclk_i(gclk),
        .gsr_i(gsr), .goe_i(goe), .cfg_role_i(role), .cfg_inv_i(inv),
        .cfg_mode_i(mode), .cfg_clk_sel_i(csel), .cfg_clk_inv_i(cinv),
        .cfg_gsr_en_i(gsr_en), .cfg_preload_i(pre), .cfg_oe_sel_i(oesel),
        .cfg_goe_idx_i(goeidx), .out_o(out_o), .oe_o(oe_o)
    );

    function automatic logic has_role(int r);
        logic acc = 1'b0;
        for (int i = 0; i < 5; i++)
            if (int'(role[i*3 +: 3]) == r && pt[i]) acc = 1'b1;
        return acc;
    endfunction

    function automatic logic m_sum();
        return (has_role(0) | casc) ^ inv;
    endfunction

    function automatic logic m_out();
        return (mode >= 2) ? m_sum() : mq;
    endfunction

    function automatic logic m_oe();
        if (oesel == 0) return has_role(4);
        if (oesel == 1) return goe[goeidx];
        return (oesel == 2);
    endfunction

    task automatic model_edge();
        logic s, c, st, e;
        if (!rst_n) begin
            mq = pre; mprev = 1'b1;
            return;
        end
        s  = (csel < 3) ? (gclk[csel] ^ cinv) : has_role(1);
        c  = has_role(3) | (gsr_en & gsr & ~pre);
        st = has_role(2) | (gsr_en & gsr & pre);
        e  = s & ~mprev;
        mprev = s;
        if (c) mq = 1'b0;
        else if (st) mq = 1'b1;
        else if (e && mode == 0) mq = m_sum();
        else if (e && mode == 1) mq = mq ^ m_sum();
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(cur_req, "out vs model", out_o, m_out());
        check(cur_req, "oe vs model", oe_o, m_oe());
    endtask

    task automatic expect_out(string req, logic exp);
        check(req, "out directed", out_o, exp);
    endtask

    task automatic set_role(int idx, int r);
        role[idx*3 +: 3] = 3'(r);
    endtask

    task automatic do_reset(logic p);
        pre = p;
        rst_n = 1'b0;
        mq = p; mprev = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        pt = '0; casc = 0; gclk = '0; gsr = 0; goe = '0; role = {5{3'd5}};
        inv = 0; mode = 0; csel = 0; cinv = 0; gsr_en = 0; pre = 0;
        oesel = 2; goeidx = 0; rst_n = 0; mq = 0; mprev = 1;
        @(negedge clk);

        cur_req = "R1";
        do_reset(1'b0);
        expect_out("R1", 1'b0);

        cur_req = "R2"; mode = 2; set_role(0, 0);
        pt = 5'b00001; tick(); expect_out("R2", 1'b1);
        pt = 5'b00010; tick(); expect_out("R2", 1'b0);
        pt = 5'b00000; casc = 1; tick(); expect_out("R2", 1'b1);
        cur_req = "R3"; casc = 0; inv = 1; tick(); expect_out("R3", 1'b1);
        pt = 5'b00001; tick(); expect_out("R3", 1'b0);
        cur_req = "R4"; inv = 0; gclk = 3'b000; tick(); gclk = 3'b001; tick();
        mode = 0; pt = 0; tick(); expect_out("R4", 1'b0);

        cur_req = "R5"; pt = 5'b00001; gclk = 0; tick(); expect_out("R5", 1'b0);
        gclk = 3'b001; tick(); expect_out("R5", 1'b1);
        pt = 0; tick(); expect_out("R5", 1'b1);
        gclk = 0; tick(); expect_out("R5", 1'b1);
        gclk = 3'b001; tick(); expect_out("R5", 1'b0);

        cur_req = "R6"; mode = 1; pt = 5'b00001;
        gclk = 0; tick(); gclk = 3'b001; tick(); expect_out("R6", 1'b1);
        gclk = 0; tick(); gclk = 3'b001; tick(); expect_out("R6", 1'b0);
        pt = 0; gclk = 0; tick(); gclk = 3'b001; tick(); expect_out("R6", 1'b0);

        cur_req = "R7"; mode = 0; pt = 5'b00001; csel = 1;
        gclk = 3'b000; tick(); gclk = 3'b001; tick(); gclk = 3'b000; tick();
        expect_out("R7", 1'b0);
        gclk = 3'b010; tick(); expect_out("R7", 1'b1);
        pt = 0; cinv = 1; tick(); expect_out("R7", 1'b1);
        gclk = 3'b000; tick(); expect_out("R7", 1'b0);
        cinv = 0; csel = 3; set_role(4, 1); pt = 5'b00001; tick();
        expect_out("R7", 1'b0);
        pt = 5'b10001; tick(); expect_out("R7", 1'b1);

        cur_req = "R8"; set_role(4, 5); csel = 0; gclk = 0;
        set_role(3, 3); set_role(2, 2);
        pt = 5'b01000; tick(); expect_out("R8", 1'b0);
        pt = 5'b00100; tick(); expect_out("R8", 1'b1);
        pt = 5'b00000; tick(); expect_out("R8", 1'b1);
        pt = 5'b01100; tick(); expect_out("R8", 1'b0);
        pt = 5'b00100; tick(); expect_out("R8", 1'b1);

        cur_req = "R9"; pt = 0; gsr_en = 1; pre = 0; gsr = 1; tick();
        expect_out("R9", 1'b0);
        gsr = 0; pre = 1; tick(); gsr = 1; tick(); expect_out("R9", 1'b1);
        gsr = 0; gsr_en = 0; pre = 0; tick(); gsr = 1; tick();
        expect_out("R9", 1'b1);
        gsr_en = 1; pre = 1; pt = 5'b01000; tick(); expect_out("R9", 1'b0);
        gsr = 0; pt = 0; gsr_en = 0;

        cur_req = "R10"; oesel = 2; tick(); check("R10", "oe const1", oe_o, 1'b1);
        oesel = 3; tick(); check("R10", "oe const0", oe_o, 1'b0);
        oesel = 1; goe = 4'b0100; goeidx = 2; tick(); check("R10", "oe glob", oe_o, 1'b1);
        goeidx = 1; tick(); check("R10", "oe glob", oe_o, 1'b0);
        oesel = 0; set_role(1, 4); pt = 5'b00010; tick(); check("R10", "oe term", oe_o, 1'b1);
        pt = 0; tick(); check("R10", "oe term", oe_o, 1'b0);

        cur_req = "R1"; do_reset(1'b1); mode = 0;
        expect_out("R1", 1'b1);
        pre = 0;

        cur_req = "R5";
        for (int k = 0; k < 1500; k++) begin
            pt = 5'($urandom); casc = ($urandom % 8) == 0; gclk = 3'($urandom);
            gsr = ($urandom % 16) == 0; goe = 4'($urandom);
            if (k % 50 == 0) begin
                for (int i = 0; i < 5; i++) set_role(i, $urandom % 8);
                inv = 1'($urandom); mode = 2'($urandom); csel = 2'($urandom);
                cinv = 1'($urandom); gsr_en = 1'($urandom); pre = 1'($urandom);
                oesel = 2'($urandom); goeidx = 2'($urandom);
            end
            tick();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule